// File: doc/BRIEF.md
# MMU Abort Status Capture Unit

This block sits beside a memory management unit and decides what gets recorded when one memory access raises faults. Each fault source raises its own flag. The block ranks the raised flags by a fixed priority and keeps only the winner. It encodes the winner as a five-bit status code, a four-bit domain field with a valid bit, and a bus-error qualifier. It then writes the instruction-side and data-side status and address registers that apply to that abort type.

Each access also supplies its side (instruction or data), a page-level qualifier, the bus response kind, the faulting virtual address, the instruction address, the domain, and a flag marking an instruction-cache maintenance operation by address. When the abort strobe is high, the block captures the result at the next clock edge and raises either a prefetch-abort or a data-abort request for one cycle. Software can overwrite any of the five registers through a simple write port.

Top module: `abort_capture`

## Requirements
- R1: When several flags are set, only the highest-ranked one is recorded. The flag input bit positions are: bit 0 alignment, bit 1 TLB miss, bit 2 external abort on translation, bit 3 translation, bit 4 access-bit, bit 5 domain, bit 6 permission, bit 7 precise external abort, bit 8 imprecise external abort, bit 9 parity, bit 10 debug event. Bit 0 has the highest rank and bit 10 the lowest.
- R2: Each status word is 13 bits wide, laid out as follows:
  - bits 3:0 hold the low four code bits;
  - bits 7:4 hold the domain;
  - bit 8 is the domain-valid flag;
  - bit 10 holds code bit 4;
  - bit 12 is the bus-error qualifier;
  - bits 9 and 11 are 0.
- R3: The codes are listed below. Where two values are given, walk_l2=0 selects the first (section or first-level) and walk_l2=1 selects the second (page or second-level).
  - alignment 00001
  - TLB miss 00000
  - external abort on translation 01100 / 01110
  - translation 00101 / 00111
  - access-bit 00011 / 00110
  - domain 01001 / 01011
  - permission 01101 / 01111
  - precise external 01000
  - imprecise external 10110
  - parity 11000
  - debug 00010
  - instruction-cache maintenance 00100
- R4: The domain-valid bit is 1, and bits 7:4 carry the domain input, for these faults:
  - second-level external abort on translation;
  - page translation;
  - both access-bit cases;
  - domain faults;
  - permission faults;
  - precise external abort;
  - debug.

  For every other fault the domain-valid bit is 0 and bits 7:4 are 0.
- R5: For the three external-abort types, bit 12 equals bus_slverr (1 means slave error, 0 means decode error). For every other type, bit 12 is 0.
- R6: On the instruction side, the alignment and TLB-miss flags are ignored. An instruction-side status word therefore never holds code 00001, 00000 or 00100.
- R7: An instruction-side abort (side_data=0) raises a prefetch-abort request and writes the instruction status register. It also writes the instruction address register with instr_addr, except when the winner is the debug event. The data status, fault address and watchpoint address registers keep their values.
- R8: A data-side access with icm_op=1 whose winner is one of flag bits 2 to 6 raises a data-abort request and writes four registers:
  - the data status register gets code 00100, with the domain invalid and bit 12 clear;
  - the instruction status register gets the real fault;
  - the fault address register gets fault_addr;
  - the instruction address register gets instr_addr.
- R9: Any other data-side abort raises a data-abort request and writes the data status register and the fault address register (from fault_addr). When the winner is the debug event, it also writes the watchpoint address register with instr_addr. The instruction-side registers keep their values.
- R10: Registers change at the clock edge that samples abort_vld=1 and then hold. The abort request is high for exactly the one cycle after that edge.
- R11: When sw_we=1, sw_wdata is written at the clock edge to the register chosen by sw_sel. The encodings are: 0 instruction status, 1 data status, 2 instruction address, 3 fault address, 4 watchpoint address. Status registers take bits 12:0. If an abort writes the same register at the same edge, the abort value wins.
- R12: An abort strobe with no flag left after masking writes nothing and raises no request.
- R13: Synchronous reset clears all registers and both requests to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_vld | input | 1 | Access has finished and its flags are to be evaluated |
| side_data | input | 1 | 1 for a data-side access, 0 for an instruction-side access |
| icm_op | input | 1 | Access is an instruction-cache maintenance operation by address |
| flags | input | 11 | Per-source fault flags, in the bit order given in R1 |
| walk_l2 | input | 1 | Selects the page / second-level variant of a code |
| bus_slverr | input | 1 | Bus response kind: 1 slave error, 0 decode error |
| domain | input | 4 | Domain of the access |
| fault_addr | input | AW | Faulting virtual address |
| instr_addr | input | AW | Address of the instruction that caused the access |
| sw_we | input | 1 | Software write enable |
| sw_sel | input | 3 | Software write target (encoding in R11) |
| sw_wdata | input | AW | Software write data |
| ifsr | output | 13 | Instruction status register |
| dfsr | output | 13 | Data status register |
| ifar | output | AW | Instruction address register |
| far | output | AW | Fault address register |
| wfar | output | AW | Watchpoint address register |
| pabt_req | output | 1 | Prefetch-abort request, one cycle |
| dabt_req | output | 1 | Data-abort request, one cycle |

## Verification
The bench drives several kinds of flag pattern:
- Pairs of simultaneous flags, to show that rank, not bit count or input order, picks the winner.
- Each flag alone with walk_l2 at both values, which separates the section and page codes and the domain-valid rule for every fault kind.
- External aborts under both bus response kinds, compared against non-external faults with bus_slverr high, to show that only external aborts carry the qualifier.
- The same fault raised on each side, with and without the maintenance flag, and the debug event on each side, to show which registers are written and which keep their earlier contents.
- A software write colliding with an abort on the same register, to show which one wins.

// File: rtl/abort_pkg.sv
package abort_pkg;
  localparam int NSRC = 11;
  localparam int SRCW = 4;
  localparam int SW   = 13;

  localparam int S_ALIGN = 0;
  localparam int S_TLB   = 1;
  localparam int S_XEXT  = 2;
  localparam int S_XLT   = 3;
  localparam int S_ACC   = 4;
  localparam int S_DOM   = 5;
  localparam int S_PERM  = 6;
  localparam int S_EXTP  = 7;
  localparam int S_EXTI  = 8;
  localparam int S_PAR   = 9;
  localparam int S_DBG   = 10;

  localparam logic [4:0] CODE_ICM = 5'b00100;

  // sources that never reach the instruction-side status word
  localparam logic [NSRC-1:0] INST_IGNORE = NSRC'((1 << S_ALIGN) | (1 << S_TLB));
  // walk-related faults that divert to the maintenance code
  localparam logic [NSRC-1:0] WALK_CLASS =
    NSRC'((1 << S_XEXT) | (1 << S_XLT) | (1 << S_ACC) | (1 << S_DOM) | (1 << S_PERM));

  typedef enum logic [2:0] {
    SEL_IFSR = 3'd0,
    SEL_DFSR = 3'd1,
    SEL_IFAR = 3'd2,
    SEL_FAR  = 3'd3,
    SEL_WFAR = 3'd4
  } sw_sel_e;

  typedef struct packed {
    logic [4:0] code;
    logic       dom_ok;
    logic       ext;
  } fault_enc_t;

  function automatic logic [SW-1:0] pack_status(fault_enc_t e, logic [3:0] dom);
    logic [SW-1:0] s;
    s        = '0;
    s[3:0]   = e.code[3:0];
    s[7:4]   = e.dom_ok ? dom : 4'd0;
    s[8]     = e.dom_ok;
    s[10]    = e.code[4];
    s[12]    = e.ext;
    return s;
  endfunction
endpackage

// File: rtl/abort_prio.sv
module abort_prio
  import abort_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]          req,
  output logic [N-1:0]          win,
  output logic [$clog2(N)-1:0]  idx,
  output logic                  any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rank
      assign win[g]    = req[g] & ~seen[g];
      assign seen[g+1] = seen[g] | req[g];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = i[$clog2(N)-1:0];
    end
  end
endmodule

// File: rtl/abort_encode.sv
module abort_encode
  import abort_pkg::*;
(
  input  logic [SRCW-1:0] idx,
  input  logic            walk_l2,
  input  logic            bus_slverr,
  output fault_enc_t      enc
);
  always_comb begin
    enc = '{code: 5'b00000, dom_ok: 1'b0, ext: 1'b0};
    case (int'(idx))
      S_ALIGN: enc.code = 5'b00001;
      S_TLB:   enc.code = 5'b00000;
      S_XEXT: begin
        enc.code   = walk_l2 ? 5'b01110 : 5'b01100;
        enc.dom_ok = walk_l2;
        enc.ext    = bus_slverr;
      end
      S_XLT: begin
        enc.code   = walk_l2 ? 5'b00111 : 5'b00101;
        enc.dom_ok = walk_l2;
      end
      S_ACC: begin
        enc.code   = walk_l2 ? 5'b00110 : 5'b00011;
        enc.dom_ok = 1'b1;
      end
      S_DOM: begin
        enc.code   = walk_l2 ? 5'b01011 : 5'b01001;
        enc.dom_ok = 1'b1;
      end
      S_PERM: begin
        enc.code   = walk_l2 ? 5'b01111 : 5'b01101;
        enc.dom_ok = 1'b1;
      end
      S_EXTP: begin
        enc.code   = 5'b01000;
        enc.dom_ok = 1'b1;
        enc.ext    = bus_slverr;
      end
      S_EXTI: begin
        enc.code = 5'b10110;
        enc.ext  = bus_slverr;
      end
      S_PAR:  enc.code = 5'b11000;
      S_DBG: begin
        enc.code   = 5'b00010;
        enc.dom_ok = 1'b1;
      end
      default: enc = '{code: 5'b00000, dom_ok: 1'b0, ext: 1'b0};
    endcase
  end
endmodule

// File: rtl/abort_capture.sv
module abort_capture
  import abort_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_vld,
  input  logic              side_data,
  input  logic              icm_op,
  input  logic [NSRC-1:0]   flags,
  input  logic              walk_l2,
  input  logic              bus_slverr,
  input  logic [3:0]        domain,
  input  logic [AW-1:0]     fault_addr,
  input  logic [AW-1:0]     instr_addr,
  input  logic              sw_we,
  input  logic [2:0]        sw_sel,
  input  logic [AW-1:0]     sw_wdata,
  output logic [SW-1:0]     ifsr,
  output logic [SW-1:0]     dfsr,
  output logic [AW-1:0]     ifar,
  output logic [AW-1:0]     far,
  output logic [AW-1:0]     wfar,
  output logic              pabt_req,
  output logic              dabt_req
);
  localparam fault_enc_t ICM_ENC = '{code: CODE_ICM, dom_ok: 1'b0, ext: 1'b0};

  logic [NSRC-1:0] live;
  logic [NSRC-1:0] win;
  logic [SRCW-1:0] idx;
  logic            any;
  fault_enc_t      enc;
  logic [SW-1:0]   st_real;
  logic [SW-1:0]   st_icm;
  logic            take;
  logic            icm_case;

  // R6: instruction side drops sources that cannot occur there
  assign live = side_data ? flags : (flags & ~INST_IGNORE);

  abort_prio #(.N(NSRC)) u_prio (
    .req (live),
    .win (win),
    .idx (idx),
    .any (any)
  );

  abort_encode u_enc (
    .idx        (idx),
    .walk_l2    (walk_l2),
    .bus_slverr (bus_slverr),
    .enc        (enc)
  );

  assign st_real  = pack_status(enc, domain);
  assign st_icm   = pack_status(ICM_ENC, domain);
  assign take     = abort_vld & any;
  assign icm_case = side_data & icm_op & |(win & WALK_CLASS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ifsr     <= '0;
      dfsr     <= '0;
      ifar     <= '0;
      far      <= '0;
      wfar     <= '0;
      pabt_req <= 1'b0;
      dabt_req <= 1'b0;
    end else begin
      pabt_req <= 1'b0;
      dabt_req <= 1'b0;
      if (sw_we) begin
        case (sw_sel_e'(sw_sel))
          SEL_IFSR: ifsr <= sw_wdata[SW-1:0];
          SEL_DFSR: dfsr <= sw_wdata[SW-1:0];
          SEL_IFAR: ifar <= sw_wdata;
          SEL_FAR:  far  <= sw_wdata;
          SEL_WFAR: wfar <= sw_wdata;
          default: ;
        endcase
      end
      if (take) begin
        if (!side_data) begin
          pabt_req <= 1'b1;
          ifsr     <= st_real;
          if (!win[S_DBG]) ifar <= instr_addr;
        end else begin
          dabt_req <= 1'b1;
          far      <= fault_addr;
          if (icm_case) begin
            dfsr <= st_icm;
            ifsr <= st_real;
            ifar <= instr_addr;
          end else begin
            dfsr <= st_real;
          end
          if (win[S_DBG]) wfar <= instr_addr;
        end
      end
    end
  end

  // R7, R9: never both abort kinds at once
  a_r7_one_kind: assert property (@(posedge clk) disable iff (rst)
    !(pabt_req && dabt_req));

  // R10: a request follows a strobe of the matching side
  a_r10_req_origin: assert property (@(posedge clk) disable iff (rst)
    pabt_req |-> ($past(abort_vld) && !$past(side_data)));

  // R6: instruction status written by an abort never holds the excluded codes
  a_r6_no_data_codes: assert property (@(posedge clk) disable iff (rst)
    pabt_req |-> !({ifsr[10], ifsr[3:0]} inside {5'b00001, 5'b00000, 5'b00100}));

  // R7: data-side registers kept on an instruction abort
  a_r7_data_kept: assert property (@(posedge clk) disable iff (rst)
    (pabt_req && !$past(sw_we)) |-> ($stable(dfsr) && $stable(far) && $stable(wfar)));

  // R4: invalid domain leaves the field clear
  a_r4_dom_clear: assert property (@(posedge clk) disable iff (rst)
    (dabt_req && !dfsr[8]) |-> (dfsr[7:4] == 4'd0));

  // R5: qualifier only on external-abort codes
  a_r5_ext_only: assert property (@(posedge clk) disable iff (rst)
    (dabt_req && dfsr[12]) |->
      ({dfsr[10], dfsr[3:0]} inside {5'b01100, 5'b01110, 5'b01000, 5'b10110}));
endmodule

// File: tb/abort_capture_bench.sv
module abort_capture_bench;
  localparam int AW = 32;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic          abort_vld, side_data, icm_op, walk_l2, bus_slverr, sw_we;
  logic [10:0]   flags;
  logic [3:0]    domain;
  logic [AW-1:0] fault_addr, instr_addr, sw_wdata;
  logic [2:0]    sw_sel;
  logic [12:0]   ifsr, dfsr;
  logic [AW-1:0] ifar, far, wfar;
  logic          pabt_req, dabt_req;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  abort_capture #(.AW(AW)) u_abort_capture (
    .clk(clk), .rst(rst), .abort_vld(abort_vld), .side_data(side_data),
    .icm_op(icm_op), .flags(flags), .walk_l2(walk_l2), .bus_slverr(bus_slverr),
    .domain(domain), .fault_addr(fault_addr), .instr_addr(instr_addr),
    .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .ifsr(ifsr), .dfsr(dfsr), .ifar(ifar), .far(far), .wfar(wfar),
    .pabt_req(pabt_req), .dabt_req(dabt_req)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected code per R3, for source index s
  function automatic logic [4:0] exp_code(int s, logic l2);
    case (s)
      0: return 5'b00001;
      1: return 5'b00000;
      2: return l2 ? 5'b01110 : 5'b01100;
      3: return l2 ? 5'b00111 : 5'b00101;
      4: return l2 ? 5'b00110 : 5'b00011;
      5: return l2 ? 5'b01011 : 5'b01001;
      6: return l2 ? 5'b01111 : 5'b01101;
      7: return 5'b01000;
      8: return 5'b10110;
      9: return 5'b11000;
      default: return 5'b00010;
    endcase
  endfunction

  // R4 rule
  function automatic logic exp_dv(int s, logic l2);
    if (s == 2 || s == 3) return l2;
    return (s >= 4 && s <= 7) || s == 10;
  endfunction

  // R2 layout and R5
  function automatic logic [12:0] exp_st(int s, logic l2, logic se, logic [3:0] d);
    logic [4:0] c;
    logic dv, x;
    c  = exp_code(s, l2);
    dv = exp_dv(s, l2);
    x  = (s == 2 || s == 7 || s == 8) ? se : 1'b0;
    return {x, 1'b0, c[4], 1'b0, dv, (dv ? d : 4'd0), c[3:0]};
  endfunction

  task automatic idle();
    abort_vld = 0; side_data = 0; icm_op = 0; flags = '0; walk_l2 = 0;
    bus_slverr = 0; domain = 0; fault_addr = 0; instr_addr = 0;
    sw_we = 0; sw_sel = 0; sw_wdata = 0;
  endtask

  // drive one abort; on return outputs reflect it (sampled after the edge)
  task automatic fire(logic sd, logic icm, logic [10:0] f, logic l2, logic se,
                       logic [3:0] d, logic [AW-1:0] va, logic [AW-1:0] ia);
    @(negedge clk);
    abort_vld = 1; side_data = sd; icm_op = icm; flags = f; walk_l2 = l2;
    bus_slverr = se; domain = d; fault_addr = va; instr_addr = ia;
    @(negedge clk);
    abort_vld = 0; flags = '0;
  endtask

  task automatic swr(logic [2:0] sel, logic [AW-1:0] v);
    @(negedge clk);
    sw_we = 1; sw_sel = sel; sw_wdata = v;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic t_reset();
    chk("R13 ifsr", ifsr, 0); chk("R13 dfsr", dfsr, 0);
    chk("R13 ifar", ifar, 0); chk("R13 far", far, 0);
    chk("R13 wfar", wfar, 0);
    chk("R13 reqs", {pabt_req, dabt_req}, 0);
  endtask

  task automatic t_priority();
    fire(1, 0, 11'b100_0100_0001, 1, 0, 4'h5, 32'h100, 32'h200);
    chk("R1 align beats perm", dfsr, exp_st(0, 1, 0, 4'h5));
    fire(1, 0, 11'b000_1100_0000, 1, 0, 4'h9, 32'h104, 32'h204);
    chk("R1 perm beats precise", dfsr, exp_st(6, 1, 0, 4'h9));
    fire(1, 0, 11'b110_0000_1000, 0, 0, 4'h3, 32'h108, 32'h208);
    chk("R1 xlt beats parity/dbg", dfsr, exp_st(3, 0, 0, 4'h3));
  endtask

  task automatic t_codes();
    for (int s = 0; s < 11; s++) begin
      for (int l = 0; l < 2; l++) begin
        fire(1, 0, 11'(1 << s), l[0], 0, 4'hA, 32'h1000 + s, 32'h2000);
        chk($sformatf("R3 R4 R2 src%0d l2=%0d", s, l), dfsr, exp_st(s, l[0], 0, 4'hA));
        chk("R9 dabt", {pabt_req, dabt_req}, 2'b01);
        chk("R9 far", far, 32'h1000 + s);
      end
    end
  endtask

  task automatic t_ext();
    fire(1, 0, 11'b000_1000_0000, 0, 1, 4'h2, 32'h300, 32'h0);
    chk("R5 precise slverr", dfsr[12], 1);
    fire(1, 0, 11'b001_0000_0000, 0, 0, 4'h2, 32'h300, 32'h0);
    chk("R5 imprecise decerr", dfsr[12], 0);
    fire(1, 0, 11'b000_0000_0100, 1, 1, 4'h2, 32'h300, 32'h0);
    chk("R5 walk ext slverr", dfsr, exp_st(2, 1, 1, 4'h2));
    fire(1, 0, 11'b000_0010_0000, 1, 1, 4'h2, 32'h300, 32'h0);
    chk("R5 domain fault no qualifier", dfsr[12], 0);
  endtask

  task automatic t_inst();
    logic [12:0] d0;
    logic [AW-1:0] f0, w0, i0;
    d0 = dfsr; f0 = far; w0 = wfar;
    fire(0, 0, 11'b000_0000_1001, 0, 0, 4'h6, 32'hAAA0, 32'hBBB0);
    chk("R6 align ignored on inst", ifsr, exp_st(3, 0, 0, 4'h6));
    chk("R7 pabt", {pabt_req, dabt_req}, 2'b10);
    chk("R7 ifar", ifar, 32'hBBB0);
    chk("R7 dfsr kept", dfsr, d0);
    chk("R7 far kept", far, f0);
    chk("R7 wfar kept", wfar, w0);
    @(negedge clk);
    chk("R10 pabt one cycle", pabt_req, 0);
    chk("R10 ifsr held", ifsr, exp_st(3, 0, 0, 4'h6));
    i0 = ifar;
    fire(0, 0, 11'b100_0000_0000, 0, 0, 4'h1, 32'hAAA4, 32'hBBB4);
    chk("R7 debug ifsr", ifsr, exp_st(10, 0, 0, 4'h1));
    chk("R7 debug ifar kept", ifar, i0);
    d0 = ifsr;
    fire(0, 0, 11'b000_0000_0010, 0, 0, 4'h1, 32'hAAA8, 32'hBBB8);
    chk("R6 tlb miss ignored: no req", {pabt_req, dabt_req}, 0);
    chk("R6 tlb miss ignored: ifsr", ifsr, d0);
  endtask

  task automatic t_icm();
    fire(1, 1, 11'b000_0001_0000, 1, 0, 4'h7, 32'hC0C0, 32'hD0D0);
    chk("R8 dfsr icm code", dfsr, 13'b0_0000_0000_0100);
    chk("R8 ifsr real", ifsr, exp_st(4, 1, 0, 4'h7));
    chk("R8 far", far, 32'hC0C0);
    chk("R8 ifar", ifar, 32'hD0D0);
    chk("R8 dabt", {pabt_req, dabt_req}, 2'b01);
    fire(1, 1, 11'b000_1000_0000, 0, 1, 4'h7, 32'hC0C4, 32'hD0D4);
    chk("R8 non-walk fault normal", dfsr, exp_st(7, 0, 1, 4'h7));
    chk("R9 ifar kept", ifar, 32'hD0D0);
  endtask

  task automatic t_dbg();
    logic [12:0] i0;
    i0 = ifsr;
    fire(1, 0, 11'b100_0000_0000, 0, 0, 4'h4, 32'hE000, 32'hF000);
    chk("R9 debug dfsr", dfsr, exp_st(10, 0, 0, 4'h4));
    chk("R9 debug wfar", wfar, 32'hF000);
    chk("R9 debug far", far, 32'hE000);
    chk("R9 ifsr kept", ifsr, i0);
    @(negedge clk);
    chk("R10 dabt one cycle", dabt_req, 0);
  endtask

  task automatic t_none();
    logic [12:0] d0;
    logic [AW-1:0] f0;
    d0 = dfsr; f0 = far;
    fire(1, 0, 11'b0, 0, 1, 4'hF, 32'h5555, 32'h6666);
    chk("R12 no req", {pabt_req, dabt_req}, 0);
    chk("R12 dfsr kept", dfsr, d0);
    chk("R12 far kept", far, f0);
  endtask

  task automatic t_sw();
    swr(3'd0, 32'h0000_1ABC); chk("R11 ifsr", ifsr, 13'h1ABC);
    swr(3'd1, 32'hFFFF_0123); chk("R11 dfsr", dfsr, 13'h0123);
    swr(3'd2, 32'h1111_2222); chk("R11 ifar", ifar, 32'h1111_2222);
    swr(3'd3, 32'h3333_4444); chk("R11 far", far, 32'h3333_4444);
    swr(3'd4, 32'h5555_6666); chk("R11 wfar", wfar, 32'h5555_6666);
    @(negedge clk);
    sw_we = 1; sw_sel = 3'd3; sw_wdata = 32'hDEAD;
    abort_vld = 1; side_data = 1; icm_op = 0; flags = 11'b000_0000_1000;
    walk_l2 = 0; bus_slverr = 0; domain = 0; fault_addr = 32'hBEEF; instr_addr = 0;
    @(negedge clk);
    sw_we = 0; abort_vld = 0; flags = '0;
    chk("R11 abort wins collision", far, 32'hBEEF);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_priority();
    t_codes();
    t_ext();
    t_inst();
    t_icm();
    t_dbg();
    t_none();
    t_sw();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule